// File: doc/BRIEF.md
# Memory Slot Hotplug Register Interface

This block tells firmware which memory-module slots are populated and raises a system control interrupt when that changes. A sideband request port carries a slot index with an add or a remove strobe. The block keeps one presence bit per slot. Software reads these bits a byte at a time through a read-only window on a byte-wide I/O port.

Every add or remove request also sets the memory-hotplug bit in an event status byte. That byte is combined with an event enable byte to drive a level interrupt. A PCI-hotplug event input sets a second status bit, which can also raise the interrupt. Status bits are cleared by writing ones to them.

When firmware has finished removing a module, it writes that slot's number to a write-only eject port. The block turns the write into a one-cycle completion pulse that carries the slot index.

Top module: `memslot_hp_regs`

## Requirements
- R1: After reset all presence bits, the event status byte and the event enable byte are zero, `sci_o` is low and `ej_valid_o` is low.
- R2: An add request for slot n (with n below NUM_SLOTS) sets bit n mod 8 of the byte read at 0xAF80 + n/8. The bit is visible from the cycle after the request.
- R3: A remove request for slot n alone clears bit n mod 8 of the byte at 0xAF80 + n/8. The bit is clear from the cycle after the request.
- R4: Both add and remove requests set bit 3 (mask 0x08) of the event status byte, which is read at 0xAFE0.
- R5: `sci_o` is high exactly when (status AND enable AND 0x0A) is nonzero. Bit 3 is memory hotplug and bit 1 is PCI hotplug. A `pci_evt_i` pulse sets status bit 1. `sci_o` follows the registered status and enable with no added delay.
- R6: A write to 0xAFE0 clears every status bit written as 1. An event that arrives in the same cycle as the clearing write keeps its bit set.
- R7: The event enable byte at 0xAFE4 is read/write and reads back the last value written.
- R8: A write of value v to 0xAFA0 gives `ej_valid_o` high for exactly the next cycle, with `ej_slot_o` = v. No other write produces the pulse.
- R9: Writes to the window 0xAF80..0xAF9F have no effect. A read of any unmapped address returns zero, including 0xAFA0, 0xAF7F and 0xAFA1. `io_rdata_o` is zero while `io_rd_i` is low.
- R10: If an add and a remove for the same slot arrive in the same cycle, the add wins and the slot bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| io_addr_i | input | 16 | I/O port address |
| io_wr_i | input | 1 | Byte write strobe |
| io_rd_i | input | 1 | Byte read strobe |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, same cycle as `io_rd_i` |
| hp_add_i | input | 1 | Slot add request |
| hp_rem_i | input | 1 | Slot remove request |
| hp_slot_i | input | 8 | Slot index of the request |
| pci_evt_i | input | 1 | PCI hotplug event, sets status bit 1 |
| sci_o | output | 1 | Interrupt level |
| ej_valid_o | output | 1 | Removal-complete pulse |
| ej_slot_o | output | 8 | Slot index carried by the pulse |

## Verification
The assertions check several rules on every cycle. An add leaves its slot bit set, and a lone remove leaves it clear. Any request marks the memory status bit. A clearing write with no event in the same cycle drops that bit. The eject pulse follows only eject writes and carries the written value, and unmapped reads return zero. Only the bench scenarios can show the whole bitmap byte layout over a sweep of slots. They also show the interrupt level over every enable value, the set-wins race against a clearing write, and enable read-back.

// File: rtl/memslot_hp_pkg.sv
package memslot_hp_pkg;
   localparam int unsigned BYTE_W      = 8;
   localparam int unsigned EVT_MEM_BIT = 3;
   localparam int unsigned EVT_PCI_BIT = 1;
   localparam logic [BYTE_W-1:0] EVT_IRQ_MASK =
      BYTE_W'((1 << EVT_MEM_BIT) | (1 << EVT_PCI_BIT));

   typedef struct packed {
      logic              add;
      logic              rem;
      logic [BYTE_W-1:0] slot;
   } hp_req_t;
endpackage

// File: rtl/memslot_bitmap.sv
module memslot_bitmap
   import memslot_hp_pkg::*;
#(
   parameter int unsigned NUM_SLOTS = 256
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  hp_req_t              req_i,
   output logic [NUM_SLOTS-1:0] map_o
);
   genvar s;
   generate
      for (s = 0; s < NUM_SLOTS; s++) begin : g_slot
         logic hit;
         assign hit = (int'(req_i.slot) == s);
         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               map_o[s] <= 1'b0;
            end else if (hit && req_i.add) begin
               map_o[s] <= 1'b1;
            end else if (hit && req_i.rem) begin
               map_o[s] <= 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/memslot_gpe.sv
module memslot_gpe
   import memslot_hp_pkg::*;
#(
   parameter logic [BYTE_W-1:0] IRQ_MASK = EVT_IRQ_MASK
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              mem_evt_i,
   input  logic              pci_evt_i,
   input  logic              sts_wr_i,
   input  logic              en_wr_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic [BYTE_W-1:0] sts_o,
   output logic [BYTE_W-1:0] en_o,
   output logic              irq_o
);
   logic [BYTE_W-1:0] set_vec;
   logic [BYTE_W-1:0] clr_vec;
   logic [BYTE_W-1:0] sts_d;

   always_comb begin
      set_vec = '0;
      set_vec[EVT_MEM_BIT] = mem_evt_i;
      set_vec[EVT_PCI_BIT] = pci_evt_i;
      clr_vec = sts_wr_i ? wdata_i : '0;
      sts_d   = (sts_o & ~clr_vec) | set_vec;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         sts_o <= '0;
         en_o  <= '0;
      end else begin
         sts_o <= sts_d;
         if (en_wr_i) en_o <= wdata_i;
      end
   end

   assign irq_o = |(sts_o & en_o & IRQ_MASK);
endmodule

// File: rtl/memslot_eject.sv
module memslot_eject
   import memslot_hp_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic              valid_o,
   output logic [BYTE_W-1:0] slot_o
);
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         valid_o <= 1'b0;
         slot_o  <= '0;
      end else begin
         valid_o <= wr_i;
         if (wr_i) slot_o <= wdata_i;
      end
   end
endmodule

// File: rtl/memslot_hp_regs.sv
module memslot_hp_regs
   import memslot_hp_pkg::*;
#(
   parameter int unsigned          NUM_SLOTS = 256,
   parameter int unsigned          ADDR_W    = 16,
   parameter logic [ADDR_W-1:0]    WIN_BASE  = 16'hAF80,
   parameter logic [ADDR_W-1:0]    EJ_ADDR   = 16'hAFA0,
   parameter logic [ADDR_W-1:0]    STS_ADDR  = 16'hAFE0,
   parameter logic [ADDR_W-1:0]    EN_ADDR   = 16'hAFE4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [15:0]       io_addr_i,
   input  logic              io_wr_i,
   input  logic              io_rd_i,
   input  logic [7:0]        io_wdata_i,
   output logic [7:0]        io_rdata_o,
   input  logic              hp_add_i,
   input  logic              hp_rem_i,
   input  logic [7:0]        hp_slot_i,
   input  logic              pci_evt_i,
   output logic              sci_o,
   output logic              ej_valid_o,
   output logic [7:0]        ej_slot_o
);
   localparam int unsigned WIN_BYTES = NUM_SLOTS / BYTE_W;
   localparam int unsigned OFF_W     = (WIN_BYTES > 1) ? $clog2(WIN_BYTES) : 1;

   generate
      if (NUM_SLOTS % BYTE_W != 0 || NUM_SLOTS < 16 || NUM_SLOTS > 256) begin : g_bad_slots
         $error("NUM_SLOTS must be a multiple of 8 between 16 and 256");
      end
      if (ADDR_W != 16) begin : g_bad_addr
         $error("ADDR_W must match the 16-bit port address");
      end
   endgenerate

   logic [NUM_SLOTS-1:0] slot_map;
   logic [BYTE_W-1:0]    gpe_sts;
   logic [BYTE_W-1:0]    gpe_en;
   logic [ADDR_W-1:0]    win_off;
   logic                 win_hit;
   logic                 slot_ok;
   hp_req_t              req;
   logic [BYTE_W-1:0]    map_bytes [WIN_BYTES];

   assign slot_ok  = int'(hp_slot_i) < NUM_SLOTS;
   assign req.add  = hp_add_i && slot_ok;
   assign req.rem  = hp_rem_i && slot_ok;
   assign req.slot = hp_slot_i;

   assign win_off = io_addr_i - WIN_BASE;
   assign win_hit = win_off < ADDR_W'(WIN_BYTES);

   genvar b;
   generate
      for (b = 0; b < WIN_BYTES; b++) begin : g_byte
         assign map_bytes[b] = slot_map[b*BYTE_W +: BYTE_W];
      end
   endgenerate

   memslot_bitmap #(.NUM_SLOTS(NUM_SLOTS)) bitmap_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (req),
      .map_o  (slot_map)
   );

   memslot_gpe #(.IRQ_MASK(EVT_IRQ_MASK)) gpe_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mem_evt_i (req.add || req.rem),
      .pci_evt_i (pci_evt_i),
      .sts_wr_i  (io_wr_i && io_addr_i == STS_ADDR),
      .en_wr_i   (io_wr_i && io_addr_i == EN_ADDR),
      .wdata_i   (io_wdata_i),
      .sts_o     (gpe_sts),
      .en_o      (gpe_en),
      .irq_o     (sci_o)
   );

   memslot_eject eject_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (io_wr_i && io_addr_i == EJ_ADDR),
      .wdata_i (io_wdata_i),
      .valid_o (ej_valid_o),
      .slot_o  (ej_slot_o)
   );

   always_comb begin
      io_rdata_o = '0;
      if (io_rd_i) begin
         if (win_hit)                     io_rdata_o = map_bytes[win_off[OFF_W-1:0]];
         else if (io_addr_i == STS_ADDR)  io_rdata_o = gpe_sts;
         else if (io_addr_i == EN_ADDR)   io_rdata_o = gpe_en;
      end
   end
endmodule

// File: rtl/memslot_hp_chk.sv
module memslot_hp_chk #(
   parameter int unsigned       NUM_SLOTS = 256,
   parameter logic [15:0]       WIN_BASE  = 16'hAF80,
   parameter logic [15:0]       EJ_ADDR   = 16'hAFA0,
   parameter logic [15:0]       STS_ADDR  = 16'hAFE0,
   parameter logic [15:0]       EN_ADDR   = 16'hAFE4
) (
   input logic                 clk_i,
   input logic                 rst_ni,
   input logic [15:0]          io_addr_i,
   input logic                 io_wr_i,
   input logic                 io_rd_i,
   input logic [7:0]           io_wdata_i,
   input logic [7:0]           io_rdata_o,
   input logic                 hp_add_i,
   input logic                 hp_rem_i,
   input logic [7:0]           hp_slot_i,
   input logic                 sci_o,
   input logic                 ej_valid_o,
   input logic [7:0]           ej_slot_o,
   input logic [NUM_SLOTS-1:0] slot_map,
   input logic [7:0]           gpe_sts,
   input logic [7:0]           gpe_en
);
   logic unmapped;
   assign unmapped = !(io_addr_i >= WIN_BASE && io_addr_i < WIN_BASE + 16'(NUM_SLOTS/8))
                     && io_addr_i != STS_ADDR && io_addr_i != EN_ADDR;

   // R2 R10
   add_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hp_add_i && int'(hp_slot_i) < NUM_SLOTS) |=> slot_map[$past(hp_slot_i)]);

   // R3
   rem_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hp_rem_i && !hp_add_i && int'(hp_slot_i) < NUM_SLOTS) |=> !slot_map[$past(hp_slot_i)]);

   // R4
   evt_marks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hp_add_i || hp_rem_i) |=> gpe_sts[3]);

   // R5
   irq_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hp_add_i && gpe_en[3] && !(io_wr_i && io_addr_i == EN_ADDR)) |=> sci_o);

   // R6
   w1c_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (io_wr_i && io_addr_i == STS_ADDR && io_wdata_i[3] && !hp_add_i && !hp_rem_i)
      |=> !gpe_sts[3]);

   // R8
   eject_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (io_wr_i && io_addr_i == EJ_ADDR) |=> (ej_valid_o && ej_slot_o == $past(io_wdata_i)));

   // R8
   eject_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(io_wr_i && io_addr_i == EJ_ADDR) |=> !ej_valid_o);

   // R9
   unmapped_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((io_rd_i && unmapped) || !io_rd_i) |-> io_rdata_o == 8'h00);
endmodule

bind memslot_hp_regs memslot_hp_chk #(
   .NUM_SLOTS (NUM_SLOTS),
   .WIN_BASE  (WIN_BASE),
   .EJ_ADDR   (EJ_ADDR),
   .STS_ADDR  (STS_ADDR),
   .EN_ADDR   (EN_ADDR)
) chk_i (.*);

// File: tb/memslot_hp_regs_tb_top.sv
module memslot_hp_regs_tb_top;
   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic [15:0] io_addr_i = '0;
   logic        io_wr_i = 1'b0;
   logic        io_rd_i = 1'b0;
   logic [7:0]  io_wdata_i = '0;
   logic [7:0]  io_rdata_o;
   logic        hp_add_i = 1'b0;
   logic        hp_rem_i = 1'b0;
   logic [7:0]  hp_slot_i = '0;
   logic        pci_evt_i = 1'b0;
   logic        sci_o;
   logic        ej_valid_o;
   logic [7:0]  ej_slot_o;

   int vecs = 0;
   int errs = 0;
   bit done = 1'b0;
   logic [255:0] model = '0;
   logic [7:0]   rd;

   always #2 clk_i = ~clk_i;

   memslot_hp_regs dut_i (.*);

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic io_read(logic [15:0] a, output logic [7:0] d);
      io_addr_i = a; io_rd_i = 1'b1;
      #1 d = io_rdata_o;
      io_rd_i = 1'b0;
   endtask

   task automatic io_write(logic [15:0] a, logic [7:0] d);
      io_addr_i = a; io_wdata_i = d; io_wr_i = 1'b1;
      @(negedge clk_i);
      io_wr_i = 1'b0;
   endtask

   task automatic hp(bit add, bit rem, logic [7:0] s);
      hp_add_i = add; hp_rem_i = rem; hp_slot_i = s;
      @(negedge clk_i);
      hp_add_i = 1'b0; hp_rem_i = 1'b0;
   endtask

   task automatic check_window(string req);
      for (int b = 0; b < 32; b++) begin
         io_read(16'hAF80 + 16'(b), rd);
         check(req, rd, model[b*8 +: 8]);
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk_i);
      if (!done) begin
         errs++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk_i);
      // R1 reset state
      check("R1 sci", {7'b0, sci_o}, 8'h00);
      check("R1 ej", {7'b0, ej_valid_o}, 8'h00);
      rst_ni = 1'b1;
      @(negedge clk_i);
      check_window("R1 map");
      io_read(16'hAFE0, rd); check("R1 sts", rd, 8'h00);
      io_read(16'hAFE4, rd); check("R1 en", rd, 8'h00);

      // R2 sweep adds
      for (int s = 0; s < 256; s++) if (s % 3 == 0) begin
         hp(1, 0, 8'(s)); model[s] = 1'b1;
      end
      check_window("R2");
      // R3 sweep removes
      for (int s = 0; s < 256; s++) if (s % 6 == 0) begin
         hp(0, 1, 8'(s)); model[s] = 1'b0;
      end
      check_window("R3");

      // R4 status after requests, R5 gated by enable
      io_read(16'hAFE0, rd); check("R4", rd, 8'h08);
      check("R5 en=0", {7'b0, sci_o}, 8'h00);
      // R7 enable read/write
      io_write(16'hAFE4, 8'h5A); io_read(16'hAFE4, rd); check("R7", rd, 8'h5A);
      io_write(16'hAFE4, 8'h08); io_read(16'hAFE4, rd); check("R7", rd, 8'h08);
      check("R5 en=08", {7'b0, sci_o}, 8'h01);

      // R6 write-one-to-clear
      io_write(16'hAFE0, 8'h08);
      io_read(16'hAFE0, rd); check("R6 clr", rd, 8'h00);
      check("R5 after clr", {7'b0, sci_o}, 8'h00);
      // R6 set wins over same-cycle clear
      io_addr_i = 16'hAFE0; io_wdata_i = 8'h08; io_wr_i = 1'b1;
      hp(1, 0, 8'd1); io_wr_i = 1'b0; model[1] = 1'b1;
      io_read(16'hAFE0, rd); check("R6 race", rd, 8'h08);
      io_write(16'hAFE0, 8'hFF);
      // R4 remove alone also marks
      hp(0, 1, 8'd3); model[3] = 1'b0;
      io_read(16'hAFE0, rd); check("R4 rem", rd, 8'h08);
      io_write(16'hAFE0, 8'hFF);

      // R5 pci status over every enable value
      pci_evt_i = 1'b1; @(negedge clk_i); pci_evt_i = 1'b0;
      for (int e = 0; e < 256; e++) begin
         io_write(16'hAFE4, 8'(e));
         check("R5 sweep", {7'b0, sci_o}, {7'b0, |(8'h02 & 8'(e) & 8'h0A)});
      end
      io_write(16'hAFE0, 8'hFF);
      check("R5 cleared", {7'b0, sci_o}, 8'h00);

      // R10 add wins
      hp(1, 1, 8'd200); model[200] = 1'b1;
      hp(1, 1, 8'd6);   model[6] = 1'b1;
      check_window("R10");

      // R9 window writes ignored, unmapped reads zero
      io_write(16'hAF85, 8'hFF); io_write(16'hAF80, 8'h00);
      check_window("R9 wr");
      io_read(16'hAFA0, rd); check("R9 ej rd", rd, 8'h00);
      io_read(16'hAF7F, rd); check("R9 lo", rd, 8'h00);
      io_read(16'hAFA1, rd); check("R9 hi", rd, 8'h00);
      io_addr_i = 16'hAF80; #1 check("R9 no rd", io_rdata_o, 8'h00);

      // R8 eject pulse
      foreach (model[i]) ;
      for (int k = 0; k < 3; k++) begin
         logic [7:0] v;
         v = (k == 0) ? 8'h00 : (k == 1) ? 8'h07 : 8'hFF;
         io_write(16'hAFA0, v);
         check("R8 valid", {7'b0, ej_valid_o}, 8'h01);
         check("R8 slot", ej_slot_o, v);
         @(negedge clk_i);
         check("R8 one cycle", {7'b0, ej_valid_o}, 8'h00);
      end
      io_write(16'hAFA1, 8'h11);
      check("R8 other addr", {7'b0, ej_valid_o}, 8'h00);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule